// File: doc/BRIEF.md
# Power-Up Output Sequencer

This block decides what the audio output stage does between reset and normal playback. After reset it sits in a power-down state: it holds the output clamp on, keeps the output level at zero and keeps the audio datapath disabled. Only the clock detection logic outside this block keeps running while it waits.

The clock manager reports through `clk_ok` whether the system clock and the frame clock are both present and valid. When that flag goes high, the sequencer releases the clamp. On each sample tick it then raises a digital output level in fixed small steps, from zero up to the midscale common-mode code. The step that lands on midscale moves the block into its run state, and from then on the datapath enable passes audio through. If `clk_ok` drops at any time, the block returns at once to power-down: the clamp comes back on and the level goes to zero.

The level output feeds the converter's output path as an offset. The state code lets neighbouring blocks track the sequence.

Top module: `pwrup_seq`

## Requirements
- R1: After reset the state code is 0 (power-down), `clamp_en` is 1, `ramp_lvl` is 0 and `dp_en` is 0.
- R2: While in power-down with `clk_ok` low, `clamp_en` stays 1, `ramp_lvl` stays 0 and `dp_en` stays 0, whatever `tick` does.
- R3: A clock edge in power-down with `clk_ok` high moves the state to code 1 (ramp) after that edge, and `clamp_en` falls to 0.
- R4: In the ramp state, an edge with `tick` and `clk_ok` both high raises `ramp_lvl` by exactly 64. An edge with `tick` low leaves `ramp_lvl` unchanged.
- R5: The ramp step that brings `ramp_lvl` to the midscale code 32768 (0x8000) also moves the state to code 2 (run) at that same edge. This happens after 512 ticks.
- R6: In the run state `ramp_lvl` holds at 32768 and `tick` has no effect on it.
- R7: An edge with `clk_ok` low in any state gives state code 0, `ramp_lvl` 0 and `clamp_en` 1 after that edge.
- R8: `dp_en` is 1 exactly when the state code is 2, and the state code never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ok | input | 1 | High while the system and frame clocks are detected valid |
| tick | input | 1 | One-cycle pulse per audio sample period |
| clamp_en | output | 1 | Holds the analog outputs at ground when high |
| ramp_lvl | output | 16 | Current output level code |
| dp_en | output | 1 | Enables the audio datapath |
| state_o | output | 2 | State code: 0 power-down, 1 ramp, 2 run |

## Verification
Each result is a function of registers that update on the clock edge where the stimulus is sampled: state, clamp, datapath enable and level all show the effect of an input one edge later, with no extra pipeline stage. The bench drives `clk_ok` and `tick` on the falling edge. Before the next rising edge it advances its own model by one step, then compares all four outputs 1 ns after that rising edge. The effect of every input therefore lands in the first check after the edge that samples it. Directed runs cover the full 512-tick ramp, clock loss in the ramp and in the run state, and ticks while clamped. A long random run with rare clock drops covers the remaining combinations.

// File: rtl/pus_pkg.sv
package pus_pkg;

  typedef enum logic [1:0] {
    PUS_OFF  = 2'd0,
    PUS_RAMP = 2'd1,
    PUS_RUN  = 2'd2
  } pus_state_e;

  // One ramp step, saturating at the target code.
  function automatic logic [31:0] pus_step(input logic [31:0] lvl,
                                           input logic [31:0] step,
                                           input logic [31:0] target);
    logic [31:0] nxt;
    nxt = lvl + step;
    if (nxt >= target) nxt = target;
    return nxt;
  endfunction

  // The step about to be taken lands on the target.
  function automatic logic pus_is_last(input logic [31:0] lvl,
                                       input logic [31:0] step,
                                       input logic [31:0] target);
    return (lvl + step) >= target;
  endfunction

endpackage

// File: rtl/pus_fsm.sv
module pus_fsm
  import pus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_ok,
  input  logic       last_step,
  output pus_state_e state_q
);

  pus_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!clk_ok) begin
      state_d = PUS_OFF;
    end else begin
      unique case (state_q)
        PUS_OFF:  state_d = PUS_RAMP;
        PUS_RAMP: if (last_step) state_d = PUS_RUN;
        PUS_RUN:  state_d = PUS_RUN;
        default:  state_d = PUS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PUS_OFF;
    else        state_q <= state_d;
  end

  // R7: clock loss forces power-down on the next edge
  a_r7_loss_to_off: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ok |=> state_q == PUS_OFF);

  // R3: valid clocks in power-down start the ramp
  a_r3_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PUS_OFF && clk_ok) |=> state_q == PUS_RAMP);

  // R5: final ramp step enters run
  a_r5_done_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PUS_RAMP && clk_ok && last_step) |=> state_q == PUS_RUN);

  // R6: run is left only through clock loss
  a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PUS_RUN && clk_ok) |=> state_q == PUS_RUN);

endmodule

// File: rtl/pus_ramp.sv
module pus_ramp
  import pus_pkg::*;
#(
  parameter int unsigned LVL_W  = 16,
  parameter int unsigned STEP   = 64,
  parameter int unsigned TARGET = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_ok,
  input  logic             tick,
  input  pus_state_e       state,
  output logic [LVL_W-1:0] lvl_q,
  output logic             last_step
);

  logic             step_now;
  logic [LVL_W-1:0] lvl_d;

  assign step_now  = clk_ok && tick && (state == PUS_RAMP);
  assign last_step = step_now && pus_is_last(32'(lvl_q), 32'(STEP), 32'(TARGET));

  always_comb begin
    lvl_d = lvl_q;
    if (!clk_ok)       lvl_d = '0;
    else if (step_now) lvl_d = LVL_W'(pus_step(32'(lvl_q), 32'(STEP), 32'(TARGET)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  // R4: each ticked step adds exactly one increment
  a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    step_now |=> (32'(lvl_q) - 32'($past(lvl_q))) == 32'(STEP));

  // R4: no tick, no movement while ramping
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PUS_RAMP && clk_ok && !tick) |=> $stable(lvl_q));

  // R7: clock loss zeroes the level
  a_r7_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_ok |=> lvl_q == '0);

endmodule

// File: rtl/pus_outmap.sv
module pus_outmap
  import pus_pkg::*;
(
  input  pus_state_e state,
  output logic       clamp_en,
  output logic       dp_en,
  output logic [1:0] state_code
);

  assign clamp_en   = (state == PUS_OFF);
  assign dp_en      = (state == PUS_RUN);
  assign state_code = state;

  // R8: datapath and clamp are never on together
  a_r8_exclusive: assert final (!(clamp_en && dp_en));

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pus_pkg::*;
#(
  parameter int unsigned LVL_W = 16,
  parameter int unsigned STEP  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_ok,
  input  logic             tick,
  output logic             clamp_en,
  output logic [LVL_W-1:0] ramp_lvl,
  output logic             dp_en,
  output logic [1:0]       state_o
);

  localparam int unsigned TARGET = 1 << (LVL_W - 1);

  pus_state_e state;
  logic       last_step;

  pus_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_ok    (clk_ok),
    .last_step (last_step),
    .state_q   (state)
  );

  pus_ramp #(
    .LVL_W  (LVL_W),
    .STEP   (STEP),
    .TARGET (TARGET)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_ok    (clk_ok),
    .tick      (tick),
    .state     (state),
    .lvl_q     (ramp_lvl),
    .last_step (last_step)
  );

  pus_outmap u_map (
    .state      (state),
    .clamp_en   (clamp_en),
    .dp_en      (dp_en),
    .state_code (state_o)
  );

  // R2: clamped output carries zero level
  a_r2_clamp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en |-> ramp_lvl == '0);

  // R6: run state sits at midscale
  a_r6_run_full: assert property (@(posedge clk) disable iff (!rst_n)
    dp_en |-> 32'(ramp_lvl) == 32'(TARGET));

  // R8: the unused state code never appears
  a_r8_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);

  // R5: level never exceeds midscale
  a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ramp_lvl) <= 32'(TARGET));

endmodule

// File: tb/pwrup_seq_tb.sv
module pwrup_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_ok = 1'b0;
  logic        tick = 1'b0;
  logic        clamp_en, dp_en;
  logic [15:0] ramp_lvl;
  logic [1:0]  state_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int unsigned m_st  = 0;
  int unsigned m_lvl = 0;

  always #4 clk = ~clk;

  pwrup_seq u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_ok   (clk_ok),
    .tick     (tick),
    .clamp_en (clamp_en),
    .ramp_lvl (ramp_lvl),
    .dp_en    (dp_en),
    .state_o  (state_o)
  );

  // Reference step: returns the tag of the rule that governs this edge.
  function automatic string model_step(input bit ok, input bit tk);
    if (!ok) begin
      m_st = 0; m_lvl = 0; return "R7";
    end
    case (m_st)
      0: begin m_st = 1; return "R3"; end
      1: begin
        if (!tk) return "R4";
        m_lvl = m_lvl + 64;
        if (m_lvl >= 32768) begin m_lvl = 32768; m_st = 2; return "R5"; end
        return "R4";
      end
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, int'(state_o), int'(m_st), "state");
    chk(tag, int'(ramp_lvl), int'(m_lvl), "level");
    chk(tag, int'(clamp_en), (m_st == 0) ? 1 : 0, "clamp");
    chk("R8", int'(dp_en), (m_st == 2) ? 1 : 0, "dp_en");
  endtask

  task automatic cycle(input bit ok, input bit tk);
    string tag;
    @(negedge clk);
    clk_ok = ok;
    tick   = tk;
    tag = model_step(ok, tk);
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7148));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: ticks while clocks invalid stay clamped at zero
    for (int i = 0; i < 20; i++) cycle(1'b0, i[0]);

    // R3 then full ramp with a tick every cycle (R4, R5)
    for (int i = 0; i < 520; i++) cycle(1'b1, 1'b1);
    chk("R5", int'(state_o), 2, "reached run");

    // R6: ticks in run leave level at midscale
    for (int i = 0; i < 10; i++) cycle(1'b1, i[0]);
    chk("R6", int'(ramp_lvl), 32768, "run level");

    // R7: loss in run
    cycle(1'b0, 1'b1);
    chk("R7", int'(clamp_en), 1, "clamp after loss in run");

    // Partial ramp with sparse ticks, then loss in ramp (R4, R7)
    for (int i = 0; i < 40; i++) cycle(1'b1, (i % 3) == 0);
    cycle(1'b0, 1'b1);
    chk("R7", int'(ramp_lvl), 0, "level after loss in ramp");

    // Random phase: rare clock drops, random ticks
    for (int i = 0; i < 30000; i++) begin
      bit ok;
      bit tk;
      ok = ($urandom % 1500) != 0;
      tk = $urandom % 2;
      cycle(ok, tk);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule